// File: doc/BRIEF.md
# Surrogate Gradient Substitution Engine

This block is the middle phase of a three-phase training step. It runs after the inference phase has stored one membrane potential per neuron in shared memory, and it finishes before the learning phase reads gradients from that memory. Each potential is a signed Q16.16 word. The engine does not compute a gradient arithmetically. It quantizes the potential into an 8-bit index and reads a 256-entry constant table. The table holds a smooth bell-shaped stand-in for the derivative of a sigmoid, and it replaces the derivative of the step function that decides whether a neuron spikes.

A controller pulses `start` with three values: the first potential's address, the first gradient address and an entry count. The engine then issues one read per cycle. Each read returns its data one cycle later. The engine forms the table index, looks up the gradient and writes it to the gradient region. Read, index, lookup and write overlap, so one entry is finished per cycle once the pipeline is full. A `done` pulse marks the end of the run.

The sequencer has four states:
- `ST_IDLE`: waits for a start.
- `ST_ISSUE`: issues the reads.
- `ST_DRAIN`: lets the last entries reach the write port.
- `ST_DONE`: asserts `done` for one cycle.

The transitions are:
- ST_IDLE → ST_ISSUE on a start with a non-zero count.
- ST_IDLE → ST_DONE on a start with a zero count.
- ST_ISSUE → ST_DRAIN when the last read is issued.
- ST_DRAIN → ST_DONE when the last write is on the port.
- ST_DONE → ST_IDLE when no start arrives.
- ST_DONE → ST_ISSUE or ST_DONE when a start arrives, chosen by the same count test as in ST_IDLE.

Top module: `sgs_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: A start accepted while `busy` is low latches `src_base`, `dst_base` and `count`. The read of entry i is presented at `src_base`+i, with `mem_rd_en` high, in cycle i+1 after the start edge, one entry per consecutive cycle, and exactly `count` reads are made.
- R3: The index of a potential p (signed Q16.16) is formed as follows. If p < -4.0 (below 0xFFFC0000 signed), the index is 0. If p ≥ 4.0 (0x00040000), the index is 255. Otherwise the index is (p + 0x40000) >> 11.
- R4: Table entry i equals floor(2^32 / (262144 + u²)), where u = (i−128)·8 + 4. This is 0.25/(1+x²/4) in Q16.16, evaluated at the centre x of bin i.
- R5: The gradient of entry i is written at `dst_base`+i, with `mem_wr_en` high, exactly 3 cycles after that entry's read is presented. Write addresses rise by one on consecutive write cycles.
- R6: `busy` is high from the cycle after the start edge through the cycle of the last write, which is `count`+3 cycles in total. Reads and writes occur only while `busy` is high.
- R7: `done` is high for the single cycle after the last write, and `busy` is low in that cycle.
- R8: A start pulse while `busy` is high is ignored. The running job keeps its base addresses and count.
- R9: A start with `count` = 0 performs no read and no write, and `done` is high in the next cycle.
- R10: A start in the cycle where `done` is high is accepted and begins a new job under the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for one job |
| src_base | input | ADDR_W | Address of the first membrane potential |
| dst_base | input | ADDR_W | Address of the first gradient |
| count | input | ADDR_W+1 | Number of entries in the job |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Gradient value to write |

## Verification
The assertions check four things on every cycle:
- Memory traffic stays inside the busy window.
- The fall of `busy` coincides with `done`.
- Consecutive writes go to rising addresses.
- Every written gradient lies between zero and 0.25.

The bench's scenarios cover the behaviour that a local property cannot show. The exact index chosen at the clamp edges and at bin boundaries needs a known potential and a computed expected value. So does the three-cycle read-to-write spacing per entry. So do the rejection of a start during a job, the empty job and a start issued in the done cycle.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_DONE
    } sgs_state_e;

    // Bell-shaped gradient 0.25/(1+x^2/4) at the centre of table bin idx.
    // bin_shift: log2 of the bin width in raw fixed-point units.
    function automatic logic [31:0] grad_entry(input int idx, input int idx_w,
                                               input int bin_shift, input int frac_w);
        longint x_q;
        longint u;
        longint den;
        x_q = (longint'(idx) - (longint'(1) <<< (idx_w - 1))) * (longint'(1) <<< bin_shift)
              + (longint'(1) <<< (bin_shift - 1));
        u   = x_q >>> (frac_w - 8);
        den = 262144 + u * u;
        return 32'((longint'(1) <<< 32) / den);
    endfunction

endpackage

// File: rtl/sgs_quantizer.sv
module sgs_quantizer #(
    parameter int DATA_W   = 32,
    parameter int FRAC_W   = 16,
    parameter int WIN_LOG2 = 2,
    parameter int IDX_W    = 8
) (
    input  logic [DATA_W-1:0] potential,
    output logic [IDX_W-1:0]  index
);
    localparam int SHIFT = FRAC_W + WIN_LOG2 + 1 - IDX_W;
    localparam logic signed [DATA_W-1:0] HI_S = DATA_W'(64'(1) << (FRAC_W + WIN_LOG2));
    localparam logic signed [DATA_W-1:0] LO_S = -HI_S;

    logic signed [DATA_W:0] shifted;

    always_comb begin
        shifted = {potential[DATA_W-1], potential} + {HI_S[DATA_W-1], HI_S};
        if ($signed(potential) < LO_S) begin
            index = '0;
        end else if ($signed(potential) >= HI_S) begin
            index = '1;
        end else begin
            index = shifted[SHIFT +: IDX_W];
        end
    end
endmodule

// File: rtl/sgs_rom.sv
module sgs_rom #(
    parameter int DATA_W   = 32,
    parameter int FRAC_W   = 16,
    parameter int WIN_LOG2 = 2,
    parameter int IDX_W    = 8
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] value
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int SHIFT   = FRAC_W + WIN_LOG2 + 1 - IDX_W;

    logic [DATA_W-1:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam logic [31:0] ENTRY_VAL = sgs_pkg::grad_entry(g, IDX_W, SHIFT, FRAC_W);
        assign tbl[g] = DATA_W'(ENTRY_VAL);
    end

    always_ff @(posedge clk) begin
        value <= tbl[idx];
    end
endmodule

// File: rtl/sgs_engine.sv
module sgs_engine #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int FRAC_W   = 16,
    parameter int WIN_LOG2 = 2,
    parameter int IDX_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ADDR_W:0]   count,
    output logic              busy,
    output logic              done,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    import sgs_pkg::*;

    localparam int CNT_W = ADDR_W + 1;

    sgs_state_e        state_q, state_d;
    logic [CNT_W-1:0]  rd_ptr_q, cnt_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic              accept;

    // pipeline stage registers
    logic              rdv_q, s1_valid_q, wr_en_q;
    logic [ADDR_W-1:0] rd_off_q, s1_off_q, wr_addr_q;
    logic [IDX_W-1:0]  idx_c, s1_idx_q;
    logic [DATA_W-1:0] grad_q;

    assign accept = start && (state_q == ST_IDLE || state_q == ST_DONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (accept) state_d = (count == '0) ? ST_DONE : ST_ISSUE;
                else        state_d = ST_IDLE;
            end
            ST_ISSUE: begin
                if (rd_ptr_q == cnt_q - CNT_W'(1)) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wr_en_q && !s1_valid_q && !rdv_q) state_d = ST_DONE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy        = (state_q == ST_ISSUE) || (state_q == ST_DRAIN);
        done        = (state_q == ST_DONE);
        mem_rd_en   = (state_q == ST_ISSUE);
        mem_rd_addr = src_q + rd_ptr_q[ADDR_W-1:0];
        mem_wr_en   = wr_en_q;
        mem_wr_addr = wr_addr_q;
        mem_wr_data = grad_q;
    end

    // job registers and read pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            src_q    <= '0;
            dst_q    <= '0;
        end else if (accept) begin
            rd_ptr_q <= '0;
            cnt_q    <= count;
            src_q    <= src_base;
            dst_q    <= dst_base;
        end else if (state_q == ST_ISSUE) begin
            rd_ptr_q <= rd_ptr_q + CNT_W'(1);
        end
    end

    // read -> index -> lookup/write pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q      <= 1'b0;
            s1_valid_q <= 1'b0;
            wr_en_q    <= 1'b0;
            rd_off_q   <= '0;
            s1_off_q   <= '0;
            s1_idx_q   <= '0;
            wr_addr_q  <= '0;
        end else begin
            rdv_q      <= (state_q == ST_ISSUE);
            rd_off_q   <= rd_ptr_q[ADDR_W-1:0];
            s1_valid_q <= rdv_q;
            s1_off_q   <= rd_off_q;
            s1_idx_q   <= idx_c;
            wr_en_q    <= s1_valid_q;
            wr_addr_q  <= dst_q + s1_off_q;
        end
    end

    sgs_quantizer #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W), .WIN_LOG2(WIN_LOG2), .IDX_W(IDX_W)
    ) u_quant (
        .potential(mem_rd_data),
        .index    (idx_c)
    );

    sgs_rom #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W), .WIN_LOG2(WIN_LOG2), .IDX_W(IDX_W)
    ) u_rom (
        .clk  (clk),
        .idx  (s1_idx_q),
        .value(grad_q)
    );
endmodule

// File: rtl/sgs_engine_chk.sv
module sgs_engine_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data
);
    p_rd_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    p_wr_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> busy);

    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_end_gives_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_wr_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == ADDR_W'($past(mem_wr_addr) + 1'b1)));

    p_grad_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_data != '0 && mem_wr_data <= DATA_W'(32'h4000)));
endmodule

bind sgs_engine sgs_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
);

// File: tb/sim_sgs_engine.sv
module sim_sgs_engine;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int NVEC   = 12;

    // potential, expected index (from R3)
    localparam logic [31:0] VEC_POT [NVEC] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h0003_FFFF, 32'h0004_0000,
        32'hFFFC_0000, 32'hFFFB_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
        32'h0000_0800, 32'h0000_07FF, 32'h0001_8000, 32'hFFFE_8000};
    localparam int VEC_IDX [NVEC] = '{
        128, 127, 255, 255, 0, 0, 255, 0, 129, 128, 176, 80};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] src_base = '0, dst_base = '0;
    logic [ADDR_W:0]   count = '0;
    logic              busy, done, mem_rd_en, mem_wr_en;
    logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
    logic [DATA_W-1:0] mem_rd_data, mem_wr_data;

    logic [31:0] mem [1024];
    int tests = 0, fails = 0;
    int cyc = 0;
    bit mon_on = 0;
    int rd_n, wr_n, busy_n;
    int rd_cyc [64];
    int exp_src, exp_dst, start_cyc;

    always #2 clk = ~clk;

    sgs_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
        .dst_base(dst_base), .count(count), .busy(busy), .done(done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_grad(input int i);
        longint u;
        u = longint'(i - 128) * 8 + 4;
        return 32'(longint'(64'd4294967296) / (262144 + u * u));
    endfunction

    // bus monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_rd_en) begin
                chk(mem_rd_addr == ADDR_W'(exp_src + rd_n), "R2 read address", mem_rd_addr, exp_src + rd_n);
                if (rd_n < 64) rd_cyc[rd_n] = cyc;
                rd_n++;
            end
            if (mem_wr_en) begin
                chk(wr_n < rd_n && wr_n < 64 && cyc == rd_cyc[wr_n] + 3, "R5 write timing",
                    cyc, (wr_n < 64) ? rd_cyc[wr_n] + 3 : -1);
                chk(mem_wr_addr == ADDR_W'(exp_dst + wr_n), "R5 write address", mem_wr_addr, exp_dst + wr_n);
                wr_n++;
            end
            if (busy) busy_n++;
        end
    end

    task automatic launch(input int src, input int dst, input int n);
        rd_n = 0; wr_n = 0; busy_n = 0;
        exp_src = src; exp_dst = dst; start_cyc = cyc;
        src_base = ADDR_W'(src); dst_base = ADDR_W'(dst); count = (ADDR_W+1)'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_job(input int n, input string tag);
        int k;
        for (k = 0; k < 2000 && !done; k++) @(negedge clk);
        chk(done, {tag, " watchdog/done"}, done, 1);
        chk(!busy, "R7 busy low at done", busy, 0);
        chk(rd_n == n, "R2 read count", rd_n, n);
        chk(wr_n == n, "R5 write count", wr_n, n);
        chk(busy_n == ((n == 0) ? 0 : n + 3), "R6 busy length", busy_n, (n == 0) ? 0 : n + 3);
        if (n > 0) chk(rd_cyc[0] == start_cyc + 1, "R2 first read cycle", rd_cyc[0], start_cyc + 1);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        fails++; tests++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        for (int i = 0; i < NVEC; i++) mem[100 + i] = VEC_POT[i];

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1 in reset",
            {busy, done, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1 after reset",
            {busy, done, mem_rd_en, mem_wr_en}, 0);
        mon_on = 1;

        // table-driven vectors: R3 index rule, R4 table values
        launch(100, 500, NVEC);
        finish_job(NVEC, "R7 vectors");
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
        for (int i = 0; i < NVEC; i++) begin
            chk(mem[500 + i] == ref_grad(VEC_IDX[i]), "R3/R4 gradient of vector", mem[500 + i],
                ref_grad(VEC_IDX[i]));
        end
        chk(mem[500 + NVEC] == (32'hDEAD_0000 | 32'(500 + NVEC)), "R5 no write past range",
            mem[500 + NVEC], 32'hDEAD_0000 | 32'(500 + NVEC));

        // R8: start during busy ignored
        for (int i = 0; i < 8; i++) mem[200 + i] = 32'(i) << 15;
        launch(200, 600, 8);
        @(negedge clk); @(negedge clk);
        src_base = '0; dst_base = '0; count = 5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_job(8, "R8 ignored start");
        for (int i = 0; i < 8; i++)
            chk(mem[600 + i] == ref_grad(128 + 16 * i), "R8 job kept", mem[600 + i], ref_grad(128 + 16 * i));
        chk(mem[0] == 32'hDEAD_0000, "R8 no write at ignored base", mem[0], 32'hDEAD_0000);

        // R10: start in the done cycle
        launch(100, 700, 4);
        finish_job(4, "R10 first");
        launch(104, 710, 3);
        finish_job(3, "R10 back-to-back");
        for (int i = 0; i < 3; i++)
            chk(mem[710 + i] == ref_grad(VEC_IDX[4 + i]), "R10 second job data", mem[710 + i],
                ref_grad(VEC_IDX[4 + i]));

        // R9: zero count
        @(negedge clk); @(negedge clk);
        launch(100, 800, 0);
        chk(done && !busy, "R9 done next cycle", {done, busy}, 2'b10);
        finish_job(0, "R9 empty");
        @(negedge clk);
        chk(mem[800] == (32'hDEAD_0000 | 32'd800), "R9 no write", mem[800], 32'hDEAD_0000 | 32'd800);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule